// File: doc/BRIEF.md
# Pt-Ordered Duplicate Track Eliminator

This block sits near the end of a track-trigger pipeline. It takes many streams of track candidates, each already sorted from highest to lowest transverse momentum (Pt), and merges them into one Pt-descending sequence. Because track finding runs in every layer at the same time and neighbouring segments overlap, the same physical track can show up on several streams. The block removes these copies and keeps the best one. The surviving tracks are dealt round-robin over a few output streams, and every output stream marks the end of each crossing.

Since the merged sequence is Pt-descending, a copy of a track can only be close to it in that sequence. The block therefore holds just a short window of recent survivors and compares each new candidate against that window, not against every other track of the crossing. A survivor leaves the window when the next candidate is lower in Pt by more than the Pt tolerance, when the window is full, or when the crossing closes.

Each input presents its head item as valid, end-of-crossing flag, Pt, phi and tracklet count. The block pulses that input's pop line when it consumes the head. The Pt and phi tolerances are inputs, so they can be programmed.

Top module: `trk_dedup`

## Requirements
- R1: After reset every out_vld, out_eoc and in_pop bit is 0 for as long as no input is valid.
- R2: No input is popped and no window action takes place in a cycle where any in_vld bit is 0.
- R3: The block consumes track heads in descending Pt order. When Pt is equal, the lower input index goes first. At most one track head is popped per cycle.
- R4: A candidate duplicates a held survivor when |ΔPt| ≤ pt_tol and |Δphi| ≤ phi_tol, both inclusive. The candidate is compared with the lowest-position matching survivor.
- R5: Of two duplicates the block keeps the one with the larger tracklet count. When the counts are equal it keeps the one with the lower input index (out_src). A winning candidate removes the old copy and joins the window at its newest end. A losing candidate is discarded.
- R6: Within one crossing, tracks leave in non-increasing Pt order.
- R7: The k-th survivor of a crossing (counting from 0) appears on output stream k mod N_OUT. Each output item carries the input index it came from.
- R8: When every input shows an end-of-crossing head, the window is first emptied. Then all inputs are popped together and every output stream raises out_eoc in the same cycle, with out_vld low.
- R9: The window holds at most WIN survivors. When a non-matching candidate finds the window full, the oldest survivor is released first, so a later copy of that survivor is no longer merged.
- R10: The oldest survivor is released before a candidate is considered whenever its Pt exceeds the candidate's Pt by more than pt_tol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_tol | input | PT_W | Pt tolerance for the duplicate test |
| phi_tol | input | PHI_W | Phi tolerance for the duplicate test |
| in_vld | input | N_IN | Head item of each input is present |
| in_eoc | input | N_IN | Head item is an end-of-crossing marker |
| in_pt | input | N_IN×PT_W | Head Pt per input |
| in_phi | input | N_IN×PHI_W | Head phi per input |
| in_cnt | input | N_IN×CNT_W | Head tracklet count per input |
| in_pop | output | N_IN | Head of that input consumed this cycle |
| out_vld | output | N_OUT | Track present on that output stream |
| out_eoc | output | N_OUT | End-of-crossing marker on that stream |
| out_pt | output | N_OUT×PT_W | Track Pt per stream |
| out_phi | output | N_OUT×PHI_W | Track phi per stream |
| out_cnt | output | N_OUT×CNT_W | Track tracklet count per stream |
| out_src | output | N_OUT×SRC_W | Input index the track came from |

## Verification
The bench builds the block with five inputs, three output streams and a window of three. With only three slots, forced release of a full window (R9) happens after four close-Pt tracks. With three streams, the round-robin wraps several times inside one crossing and restarts at stream 0 on the next crossing. The tolerances are set per scenario, so both the inclusive edge of the duplicate test and the value one past it are exercised on Pt and on phi. The Pt values are chosen so that equal-Pt ties between inputs and equal-count quality ties both occur.

// File: rtl/trk_dedup_pkg.sv
package trk_dedup_pkg;

  typedef enum logic [2:0] {
    ACT_WAIT,
    ACT_EJECT,
    ACT_DROP,
    ACT_SWAP,
    ACT_APPEND,
    ACT_FLUSH,
    ACT_CLOSE
  } act_e;

  function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic near(input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] tol);
    return abs_gap(a, b) <= tol;
  endfunction

  function automatic logic beats(input logic [31:0] cnt_a, input logic [31:0] src_a,
                                 input logic [31:0] cnt_b, input logic [31:0] src_b);
    return (cnt_a > cnt_b) || ((cnt_a == cnt_b) && (src_a < src_b));
  endfunction

endpackage

// File: rtl/trk_merge.sv
module trk_merge #(
  parameter int N_IN  = 36,
  parameter int PT_W  = 8,
  parameter int SRC_W = 6
) (
  input  logic [N_IN-1:0]           in_vld,
  input  logic [N_IN-1:0]           in_eoc,
  input  logic [N_IN-1:0][PT_W-1:0] in_pt,
  output logic                      all_here,
  output logic                      any_trk,
  output logic [SRC_W-1:0]          sel_idx
);

  logic [N_IN-1:0] is_trk;
  logic [PT_W-1:0] best_pt;
  logic            seen;

  genvar g;
  generate
    for (g = 0; g < N_IN; g++) begin : g_head
      assign is_trk[g] = in_vld[g] & ~in_eoc[g];
    end
  endgenerate

  assign all_here = &in_vld;
  assign any_trk  = |is_trk;

  // strict compare keeps the lowest index on equal Pt
  always_comb begin
    best_pt = '0;
    seen    = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (is_trk[i] && (!seen || (in_pt[i] > best_pt))) begin
        seen    = 1'b1;
        best_pt = in_pt[i];
        sel_idx = SRC_W'(i);
      end
    end
  end

endmodule

// File: rtl/trk_window.sv
module trk_window
  import trk_dedup_pkg::*;
#(
  parameter int WIN   = 4,
  parameter int PT_W  = 8,
  parameter int PHI_W = 8,
  parameter int CNT_W = 2,
  parameter int SRC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             any_trk,
  input  logic [PT_W-1:0]  pt_tol,
  input  logic [PHI_W-1:0] phi_tol,
  input  logic [PT_W-1:0]  cand_pt,
  input  logic [PHI_W-1:0] cand_phi,
  input  logic [CNT_W-1:0] cand_cnt,
  input  logic [SRC_W-1:0] cand_src,
  output logic             take_cand,
  output logic             close_xing,
  output logic             emit_vld,
  output logic [PT_W-1:0]  emit_pt,
  output logic [PHI_W-1:0] emit_phi,
  output logic [CNT_W-1:0] emit_cnt,
  output logic [SRC_W-1:0] emit_src,
  output act_e             act
);

  localparam int FW = $clog2(WIN + 1);
  localparam int MW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [PT_W-1:0]  w_pt  [WIN];
  logic [PHI_W-1:0] w_phi [WIN];
  logic [CNT_W-1:0] w_cnt [WIN];
  logic [SRC_W-1:0] w_src [WIN];
  logic [FW-1:0]    fill;

  logic [WIN-1:0]   hit;
  logic [MW-1:0]    m_idx;
  logic             head_far;
  logic             cand_wins;
  logic             win_full;
  logic [MW-1:0]    last_slot;
  logic [MW-1:0]    tail_slot;

  genvar g;
  generate
    for (g = 0; g < WIN; g++) begin : g_cmp
      assign hit[g] = (FW'(g) < fill)
                   && near(32'(w_pt[g]),  32'(cand_pt),  32'(pt_tol))
                   && near(32'(w_phi[g]), 32'(cand_phi), 32'(phi_tol));
    end
  endgenerate

  always_comb begin
    m_idx = '0;
    for (int j = WIN - 1; j >= 0; j--) begin
      if (hit[j]) m_idx = MW'(j);
    end
  end

  assign head_far  = (fill != '0) && (32'(w_pt[0]) > (32'(cand_pt) + 32'(pt_tol)));
  assign cand_wins = beats(32'(cand_cnt), 32'(cand_src), 32'(w_cnt[m_idx]), 32'(w_src[m_idx]));
  assign win_full  = (fill == FW'(WIN));
  assign last_slot = MW'(fill - FW'(1));
  assign tail_slot = MW'(fill);

  always_comb begin
    act = ACT_WAIT;
    if (go) begin
      if (any_trk) begin
        if (head_far)      act = ACT_EJECT;
        else if (|hit)     act = cand_wins ? ACT_SWAP : ACT_DROP;
        else if (win_full) act = ACT_EJECT;
        else               act = ACT_APPEND;
      end else begin
        act = (fill != '0) ? ACT_FLUSH : ACT_CLOSE;
      end
    end
  end

  assign take_cand  = (act == ACT_DROP) || (act == ACT_SWAP) || (act == ACT_APPEND);
  assign close_xing = (act == ACT_CLOSE);
  assign emit_vld   = (act == ACT_EJECT) || (act == ACT_FLUSH);
  assign emit_pt    = w_pt[0];
  assign emit_phi   = w_phi[0];
  assign emit_cnt   = w_cnt[0];
  assign emit_src   = w_src[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int k = 0; k < WIN; k++) begin
        w_pt[k]  <= '0;
        w_phi[k] <= '0;
        w_cnt[k] <= '0;
        w_src[k] <= '0;
      end
    end else begin
      case (act)
        ACT_EJECT, ACT_FLUSH: begin
          for (int k = 0; k < WIN - 1; k++) begin
            w_pt[k]  <= w_pt[k+1];
            w_phi[k] <= w_phi[k+1];
            w_cnt[k] <= w_cnt[k+1];
            w_src[k] <= w_src[k+1];
          end
          fill <= fill - FW'(1);
        end
        ACT_SWAP: begin
          for (int k = 0; k < WIN - 1; k++) begin
            if ((k >= int'(m_idx)) && ((k + 1) < int'(fill))) begin
              w_pt[k]  <= w_pt[k+1];
              w_phi[k] <= w_phi[k+1];
              w_cnt[k] <= w_cnt[k+1];
              w_src[k] <= w_src[k+1];
            end
          end
          w_pt[last_slot]  <= cand_pt;
          w_phi[last_slot] <= cand_phi;
          w_cnt[last_slot] <= cand_cnt;
          w_src[last_slot] <= cand_src;
        end
        ACT_APPEND: begin
          w_pt[tail_slot]  <= cand_pt;
          w_phi[tail_slot] <= cand_phi;
          w_cnt[tail_slot] <= cand_cnt;
          w_src[tail_slot] <= cand_src;
          fill <= fill + FW'(1);
        end
        default: ;
      endcase
    end
  end

  // assertion-side history of released Pt within a crossing
  logic            seen_emit;
  logic [PT_W-1:0] prev_pt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_emit <= 1'b0;
      prev_pt   <= '0;
    end else if (close_xing) begin
      seen_emit <= 1'b0;
    end else if (emit_vld) begin
      seen_emit <= 1'b1;
      prev_pt   <= emit_pt;
    end
  end

  a_r9_fill_limit: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(WIN));

  a_r2_idle_when_missing: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> (!take_cand && !close_xing && !emit_vld));

  a_r6_descending: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_vld && seen_emit) |-> (emit_pt <= prev_pt));

  a_r8_close_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    close_xing |-> (fill == '0));

endmodule

// File: rtl/trk_deal.sv
module trk_deal #(
  parameter int N_OUT = 4,
  parameter int PT_W  = 8,
  parameter int PHI_W = 8,
  parameter int CNT_W = 2,
  parameter int SRC_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        emit_vld,
  input  logic                        close_xing,
  input  logic [PT_W-1:0]             emit_pt,
  input  logic [PHI_W-1:0]            emit_phi,
  input  logic [CNT_W-1:0]            emit_cnt,
  input  logic [SRC_W-1:0]            emit_src,
  output logic [N_OUT-1:0]            out_vld,
  output logic [N_OUT-1:0]            out_eoc,
  output logic [N_OUT-1:0][PT_W-1:0]  out_pt,
  output logic [N_OUT-1:0][PHI_W-1:0] out_phi,
  output logic [N_OUT-1:0][CNT_W-1:0] out_cnt,
  output logic [N_OUT-1:0][SRC_W-1:0] out_src
);

  localparam int RW = (N_OUT > 1) ? $clog2(N_OUT) : 1;

  logic [RW-1:0] rr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr      <= '0;
      out_vld <= '0;
      out_eoc <= '0;
      out_pt  <= '0;
      out_phi <= '0;
      out_cnt <= '0;
      out_src <= '0;
    end else begin
      for (int o = 0; o < N_OUT; o++) begin
        out_vld[o] <= emit_vld && (rr == RW'(o));
        out_eoc[o] <= close_xing;
        if (emit_vld && (rr == RW'(o))) begin
          out_pt[o]  <= emit_pt;
          out_phi[o] <= emit_phi;
          out_cnt[o] <= emit_cnt;
          out_src[o] <= emit_src;
        end
      end
      if (close_xing)    rr <= '0;
      else if (emit_vld) rr <= (rr == RW'(N_OUT - 1)) ? '0 : rr + RW'(1);
    end
  end

  a_r7_single_stream: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_vld));

  a_r8_eoc_together: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_eoc) |-> ((&out_eoc) && (out_vld == '0)));

  a_r7_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (close_xing && !emit_vld) |=> (rr == '0));

endmodule

// File: rtl/trk_dedup.sv
module trk_dedup
  import trk_dedup_pkg::*;
#(
  parameter int N_IN  = 36,
  parameter int N_OUT = 4,
  parameter int WIN   = 4,
  parameter int PT_W  = 8,
  parameter int PHI_W = 8,
  parameter int CNT_W = 2,
  localparam int SRC_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PT_W-1:0]             pt_tol,
  input  logic [PHI_W-1:0]            phi_tol,
  input  logic [N_IN-1:0]             in_vld,
  input  logic [N_IN-1:0]             in_eoc,
  input  logic [N_IN-1:0][PT_W-1:0]   in_pt,
  input  logic [N_IN-1:0][PHI_W-1:0]  in_phi,
  input  logic [N_IN-1:0][CNT_W-1:0]  in_cnt,
  output logic [N_IN-1:0]             in_pop,
  output logic [N_OUT-1:0]            out_vld,
  output logic [N_OUT-1:0]            out_eoc,
  output logic [N_OUT-1:0][PT_W-1:0]  out_pt,
  output logic [N_OUT-1:0][PHI_W-1:0] out_phi,
  output logic [N_OUT-1:0][CNT_W-1:0] out_cnt,
  output logic [N_OUT-1:0][SRC_W-1:0] out_src
);

  logic             all_here;
  logic             any_trk;
  logic [SRC_W-1:0] sel_idx;
  logic             take_cand;
  logic             close_xing;
  logic             emit_vld;
  logic [PT_W-1:0]  emit_pt;
  logic [PHI_W-1:0] emit_phi;
  logic [CNT_W-1:0] emit_cnt;
  logic [SRC_W-1:0] emit_src;
  act_e             act;

  trk_merge #(.N_IN(N_IN), .PT_W(PT_W), .SRC_W(SRC_W)) u_merge (
    .in_vld   (in_vld),
    .in_eoc   (in_eoc),
    .in_pt    (in_pt),
    .all_here (all_here),
    .any_trk  (any_trk),
    .sel_idx  (sel_idx)
  );

  trk_window #(.WIN(WIN), .PT_W(PT_W), .PHI_W(PHI_W), .CNT_W(CNT_W), .SRC_W(SRC_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (all_here),
    .any_trk    (any_trk),
    .pt_tol     (pt_tol),
    .phi_tol    (phi_tol),
    .cand_pt    (in_pt[sel_idx]),
    .cand_phi   (in_phi[sel_idx]),
    .cand_cnt   (in_cnt[sel_idx]),
    .cand_src   (sel_idx),
    .take_cand  (take_cand),
    .close_xing (close_xing),
    .emit_vld   (emit_vld),
    .emit_pt    (emit_pt),
    .emit_phi   (emit_phi),
    .emit_cnt   (emit_cnt),
    .emit_src   (emit_src),
    .act        (act)
  );

  trk_deal #(.N_OUT(N_OUT), .PT_W(PT_W), .PHI_W(PHI_W), .CNT_W(CNT_W), .SRC_W(SRC_W)) u_deal (
    .clk        (clk),
    .rst_n      (rst_n),
    .emit_vld   (emit_vld),
    .close_xing (close_xing),
    .emit_pt    (emit_pt),
    .emit_phi   (emit_phi),
    .emit_cnt   (emit_cnt),
    .emit_src   (emit_src),
    .out_vld    (out_vld),
    .out_eoc    (out_eoc),
    .out_pt     (out_pt),
    .out_phi    (out_phi),
    .out_cnt    (out_cnt),
    .out_src    (out_src)
  );

  genvar g;
  generate
    for (g = 0; g < N_IN; g++) begin : g_pop
      assign in_pop[g] = (take_cand && (sel_idx == SRC_W'(g))) || close_xing;
    end
  endgenerate

  a_r2_no_pop_missing: assert property (@(posedge clk) disable iff (!rst_n)
    !(&in_vld) |-> (in_pop == '0));

  a_r3_single_track_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !$onehot0(in_pop) |-> ((&in_pop) && (&in_eoc)));

  a_r8_close_needs_all_markers: assert property (@(posedge clk) disable iff (!rst_n)
    (&in_pop && N_IN > 1) |-> (&in_eoc));

endmodule

// File: tb/trk_dedup_test.sv
`timescale 1ns/1ps
module trk_dedup_test;

  localparam int NI = 5;
  localparam int NO = 3;
  localparam int W  = 3;
  localparam int PW = 8;
  localparam int HW = 8;
  localparam int CW = 2;
  localparam int SW = 3;

  typedef struct {
    bit eoc;
    int pt;
    int phi;
    int cnt;
    int src;
  } item_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst_n;
  logic [PW-1:0]          pt_tol;
  logic [HW-1:0]          phi_tol;
  logic [NI-1:0]          in_vld;
  logic [NI-1:0]          in_eoc;
  logic [NI-1:0][PW-1:0]  in_pt;
  logic [NI-1:0][HW-1:0]  in_phi;
  logic [NI-1:0][CW-1:0]  in_cnt;
  logic [NI-1:0]          in_pop;
  logic [NO-1:0]          out_vld;
  logic [NO-1:0]          out_eoc;
  logic [NO-1:0][PW-1:0]  out_pt;
  logic [NO-1:0][HW-1:0]  out_phi;
  logic [NO-1:0][CW-1:0]  out_cnt;
  logic [NO-1:0][SW-1:0]  out_src;

  trk_dedup #(.N_IN(NI), .N_OUT(NO), .WIN(W), .PT_W(PW), .PHI_W(HW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .pt_tol(pt_tol), .phi_tol(phi_tol),
    .in_vld(in_vld), .in_eoc(in_eoc), .in_pt(in_pt), .in_phi(in_phi), .in_cnt(in_cnt),
    .in_pop(in_pop), .out_vld(out_vld), .out_eoc(out_eoc), .out_pt(out_pt),
    .out_phi(out_phi), .out_cnt(out_cnt), .out_src(out_src)
  );

  item_t sq [NI][$];
  item_t eq [NO][$];
  bit    hold [NI];
  logic [NI-1:0] pops_s;
  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 0;
  int unsigned lfsr = 32'h1ACE5EED;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < NI; i++) begin
      in_vld[i] = (sq[i].size() > 0) && !hold[i];
      if (sq[i].size() > 0) begin
        in_eoc[i] = sq[i][0].eoc;
        in_pt[i]  = PW'(sq[i][0].pt);
        in_phi[i] = HW'(sq[i][0].phi);
        in_cnt[i] = CW'(sq[i][0].cnt);
      end else begin
        in_eoc[i] = 1'b0;
        in_pt[i]  = '0;
        in_phi[i] = '0;
        in_cnt[i] = '0;
      end
    end
  endtask

  always @(negedge clk) pops_s <= in_pop;

  always @(posedge clk) begin
    #1;
    for (int i = 0; i < NI; i++)
      if (pops_s[i] && sq[i].size() > 0) void'(sq[i].pop_front());
    drive();
  end

  // monitor: compare each output item with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (|out_eoc) chk(&out_eoc, "R8", "eoc on all streams", int'(out_eoc), (1 << NO) - 1);
      for (int o = 0; o < NO; o++) begin
        if (out_vld[o] || out_eoc[o]) begin
          if (eq[o].size() == 0) begin
            chk(0, tag, "unexpected output", o, -1);
          end else begin
            item_t e;
            e = eq[o].pop_front();
            if (e.eoc) begin
              chk(out_eoc[o] && !out_vld[o], "R8", "marker expected", int'(out_vld[o]), 0);
            end else begin
              int a;
              int x;
              a = int'(out_pt[o]) * 65536 + int'(out_phi[o]) * 256 + int'(out_cnt[o]) * 16 + int'(out_src[o]);
              x = e.pt * 65536 + e.phi * 256 + e.cnt * 16 + e.src;
              chk(out_vld[o] && (a == x), tag, $sformatf("stream %0d track", o), a, x);
            end
          end
        end
      end
    end
  end

  function automatic int rnd(input int m);
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hD0000001 : 32'h0);
    return int'(lfsr % m);
  endfunction

  task automatic add(input int s, input int pt, input int phi, input int cnt);
    item_t it;
    it.eoc = 0; it.pt = pt; it.phi = phi; it.cnt = cnt; it.src = s;
    sq[s].push_back(it);
  endtask

  task automatic close_all();
    item_t it;
    it.eoc = 1; it.pt = 0; it.phi = 0; it.cnt = 0; it.src = 0;
    for (int s = 0; s < NI; s++) sq[s].push_back(it);
  endtask

  // reference model written from the requirements
  task automatic build_expect(input int ptol, input int htol);
    item_t cp [NI][$];
    item_t win [$];
    int rr;
    rr = 0;
    for (int i = 0; i < NI; i++) cp[i] = sq[i];
    forever begin
      int b;
      bit any_left;
      any_left = 0;
      for (int i = 0; i < NI; i++) if (cp[i].size() > 0) any_left = 1;
      if (!any_left) break;
      b = -1;
      for (int i = 0; i < NI; i++)
        if (cp[i].size() > 0 && !cp[i][0].eoc)
          if (b < 0 || cp[i][0].pt > cp[b][0].pt) b = i;
      if (b >= 0) begin
        item_t c;
        int m;
        c = cp[b][0];
        if (win.size() > 0 && win[0].pt - c.pt > ptol) begin
          eq[rr].push_back(win.pop_front()); rr = (rr + 1) % NO;
          continue;
        end
        m = -1;
        for (int j = 0; j < win.size(); j++) begin
          int dp, dh;
          dp = win[j].pt - c.pt;   if (dp < 0) dp = -dp;
          dh = win[j].phi - c.phi; if (dh < 0) dh = -dh;
          if (m < 0 && dp <= ptol && dh <= htol) m = j;
        end
        if (m >= 0) begin
          void'(cp[b].pop_front());
          if (c.cnt > win[m].cnt || (c.cnt == win[m].cnt && c.src < win[m].src)) begin
            win.delete(m);
            win.push_back(c);
          end
          continue;
        end
        if (win.size() == W) begin
          eq[rr].push_back(win.pop_front()); rr = (rr + 1) % NO;
          continue;
        end
        win.push_back(c);
        void'(cp[b].pop_front());
      end else begin
        item_t mk;
        while (win.size() > 0) begin
          eq[rr].push_back(win.pop_front()); rr = (rr + 1) % NO;
        end
        mk.eoc = 1; mk.pt = 0; mk.phi = 0; mk.cnt = 0; mk.src = 0;
        for (int o = 0; o < NO; o++) eq[o].push_back(mk);
        rr = 0;
        for (int i = 0; i < NI; i++) if (cp[i].size() > 0) void'(cp[i].pop_front());
      end
    end
  endtask

  task automatic drain();
    int n;
    n = 0;
    forever begin
      bit busy;
      @(negedge clk);
      busy = 0;
      for (int i = 0; i < NI; i++) if (sq[i].size() > 0) busy = 1;
      for (int o = 0; o < NO; o++) if (eq[o].size() > 0) busy = 1;
      if (!busy) break;
      n++;
      if (n > 3000) begin
        chk(0, tag, "scenario did not drain", n, 0);
        break;
      end
    end
    repeat (3) @(negedge clk);
    for (int o = 0; o < NO; o++) chk(eq[o].size() == 0, tag, "leftover expected items", eq[o].size(), 0);
  endtask

  task automatic run(input string t, input int ptol, input int htol);
    tag = t;
    pt_tol = PW'(ptol);
    phi_tol = HW'(htol);
    build_expect(ptol, htol);
    drain();
  endtask

  task automatic gen_crossing(input int maxn);
    for (int s = 0; s < NI; s++) begin
      int n, pt;
      n = rnd(maxn + 1);
      pt = 150 + rnd(60);
      for (int k = 0; k < n; k++) begin
        add(s, pt, rnd(12), rnd(4));
        pt = pt - rnd(5);
      end
    end
    close_all();
  endtask

  initial begin
    rst_n = 1'b0;
    pt_tol = '0; phi_tol = '0;
    for (int i = 0; i < NI; i++) hold[i] = 0;
    drive();
    repeat (4) @(negedge clk);
    // R1: idle outputs under reset
    chk(out_vld == '0 && out_eoc == '0, "R1", "outputs in reset", int'(out_vld), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_vld == '0 && out_eoc == '0, "R1", "outputs after reset", int'(out_eoc), 0);
    chk(in_pop == '0, "R1", "no pops after reset", int'(in_pop), 0);

    // R3: merge order with an equal-Pt tie
    add(0, 100, 10, 1); add(0, 40, 20, 1);
    add(1, 120, 30, 1);
    add(2, 100, 50, 1);
    add(4, 70, 90, 2);
    close_all();
    run("R3", 0, 0);

    // R4: inclusive tolerance edge and one past it
    add(0, 200, 10, 1);
    add(1, 198, 13, 1);
    add(2, 197, 10, 1);
    add(3, 150, 20, 0); add(3, 150, 24, 0);
    add(4, 120, 60, 1);
    add(0, 117, 60, 1);
    close_all();
    run("R4", 2, 3);

    // R5: quality selection, count first then lower input index
    add(3, 90, 40, 1);
    add(0, 89, 41, 1);
    add(4, 88, 40, 3);
    add(1, 87, 41, 0);
    add(2, 60, 5, 2);
    close_all();
    run("R5", 3, 2);

    // R9: full window forces out the oldest survivor
    add(0, 100, 1, 1); add(0, 99, 2, 1); add(0, 98, 3, 1); add(0, 97, 4, 1);
    add(1, 96, 1, 3);
    close_all();
    run("R9", 10, 0);

    // R10: Pt gap releases the head before comparison
    add(0, 80, 7, 0);
    add(1, 75, 7, 3);
    add(2, 74, 7, 1);
    close_all();
    run("R10", 4, 0);

    // R7: round-robin wraps and restarts on the next crossing
    for (int k = 0; k < 7; k++) add(k % NI, 200 - 10 * k, k * 3, 1);
    close_all();
    for (int k = 0; k < 4; k++) add(k, 100 - 5 * k, 40 + k * 5, 2);
    close_all();
    run("R7", 1, 1);

    // R8: crossing with no tracks at all
    close_all();
    run("R8", 1, 1);

    // R2: one input missing holds everything
    hold[2] = 1;
    add(0, 60, 1, 1); add(1, 59, 9, 1); add(2, 58, 20, 1);
    close_all();
    tag = "R2";
    pt_tol = PW'(1); phi_tol = HW'(1);
    build_expect(1, 1);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(in_pop == '0, "R2", "pop while input missing", int'(in_pop), 0);
      chk(out_vld == '0, "R2", "output while input missing", int'(out_vld), 0);
    end
    hold[2] = 0;
    drain();

    // R6: pseudo-random crossings with many near duplicates
    for (int c = 0; c < 8; c++) begin
      gen_crossing(5);
      run("R6", 2, 2);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog %s actual=%0d expected=%0d", tag, 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule